// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A tester drives a test clock, a mode-select line and a serial data input. The block walks the sixteen-state test-port state machine and holds a 4-bit instruction. It shifts data through one of three serial paths: a one-bit pass-through register, a fixed 32-bit device identity register, or an external boundary register. That last path is reached through a serial-return input and a set of capture, shift and update strobes.

The identity value is hard-wired to 0xC3C3C3C3. The instruction register always captures the pattern 1001. Opcode 0000 selects the boundary path with external drive, 0001 selects the boundary path for observation only, 0010 selects the identity register, and every other code behaves like the all-ones pass-through code. Serial output is registered on the falling clock edge. It comes with a separate enable that is high only while a shift state is active, and an outer pad drives the pin from the two.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: With `rst` high at a rising `tck` edge the state becomes Test-Logic-Reset (`tap_state` = 4'hF). By the following falling edge `instr` is 4'b0010 (identity) and `tdo_oe` is 0.
- R2: Five rising edges with `tms` high bring the machine to Test-Logic-Reset from any state. The instruction then reads 4'b0010 from the next falling edge.
- R3: State moves follow the standard test-port graph, evaluated on the rising `tck` edge. The state codes on `tap_state` include Run-Test/Idle = 4'hC, Shift-DR = 4'h2 and Shift-IR = 4'hA.
- R4: On the rising edge that leaves Capture-IR, the instruction shift register loads 4'b1001. The first four bits out on `tdo` in Shift-IR are therefore 1, 0, 0, 1.
- R5: Shifting is least-significant bit first, so the first `tdi` bit lands in `instr[0]`. `instr` keeps its old value through Exit1-IR and takes the shifted value on the falling edge in Update-IR.
- R6: Under the identity instruction, a data scan returns 0xC3C3C3C3 least-significant bit first. The bits after that are `tdi` delayed by 32 clocks.
- R7: Opcode 4'b1111 and every undefined opcode (for example 4'b0101) select the one-bit pass-through register. It captures 0, and after that `tdo` is `tdi` delayed by one clock. `bsr_sel` stays 0.
- R8: Opcodes 4'b0000 and 4'b0001 set `bsr_sel`, and `tdo` in Shift-DR then follows `bsr_so`. `bsr_extest` is 1 only for 4'b0000.
- R9: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 exactly in the low phases spent in Shift-IR or Shift-DR.
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively. They are high only while the boundary path is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Active-high reset, sampled on both `tck` edges |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsr_so | input | 1 | Serial return from the external boundary register |
| tdo | output | 1 | Serial data out, valid when `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for the serial data pad |
| tap_state | output | 4 | Current state code |
| instr | output | 4 | Active instruction |
| bsr_sel | output | 1 | Boundary path selected |
| bsr_extest | output | 1 | Boundary register drives chip outputs |
| bsr_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bsr_shift | output | 1 | Boundary shift strobe (Shift-DR) |
| bsr_update | output | 1 | Boundary update strobe (Update-DR) |

## Verification
A state change and a register capture take effect on the rising edge that follows the low phase in which `tms` was set. A serial output bit and a new instruction become visible on the next falling edge, which is half a period later. The bench changes inputs just after each falling edge and reads every output a quarter period after that edge, when that phase's values are settled. The scoreboard monitor takes one expected bit from the queue for each low phase with the output enable high. It then reads `tdo` again a quarter period after the following rising edge to confirm that the bit did not move there.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET    = 4'hF,
        ST_IDLE     = 4'hC,
        ST_SEL_DR   = 4'h7,
        ST_CAP_DR   = 4'h6,
        ST_SH_DR    = 4'h2,
        ST_EX1_DR   = 4'h1,
        ST_PAUSE_DR = 4'h3,
        ST_EX2_DR   = 4'h0,
        ST_UPD_DR   = 4'h5,
        ST_SEL_IR   = 4'h4,
        ST_CAP_IR   = 4'hE,
        ST_SH_IR    = 4'hA,
        ST_EX1_IR   = 4'h9,
        ST_PAUSE_IR = 4'hB,
        ST_EX2_IR   = 4'h8,
        ST_UPD_IR   = 4'hD
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_PASS  = 2'd0,
        PATH_IDENT = 2'd1,
        PATH_BOUND = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     drive_out;
    } decode_t;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDENT  = 4'b0010;
    localparam logic [IR_W-1:0] OP_PASS   = 4'b1111;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b1001;

    localparam logic [3:0]  ID_VER   = 4'b1100;
    localparam logic [15:0] ID_PART  = 16'b0011110000111100;
    localparam logic [10:0] ID_MAKER = 11'b00111100001;
    localparam logic [ID_W-1:0] ID_VALUE = {ID_VER, ID_PART, ID_MAKER, 1'b1};

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:     n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR:   n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR:   n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:    n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR:   n = tms ? ST_UPD_DR : ST_PAUSE_DR;
            ST_PAUSE_DR: n = tms ? ST_EX2_DR : ST_PAUSE_DR;
            ST_EX2_DR:   n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR:   n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR:   n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:    n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR:   n = tms ? ST_UPD_IR : ST_PAUSE_IR;
            ST_PAUSE_IR: n = tms ? ST_EX2_IR : ST_PAUSE_IR;
            ST_EX2_IR:   n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR:   n = tms ? ST_SEL_DR : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic decode_t ir_decode(input logic [IR_W-1:0] op);
        decode_t d;
        d.drive_out = 1'b0;
        case (op)
            OP_EXTEST: begin
                d.path      = PATH_BOUND;
                d.drive_out = 1'b1;
            end
            OP_SAMPLE: d.path = PATH_BOUND;
            OP_IDENT:  d.path = PATH_IDENT;
            default:   d.path = PATH_PASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state_o,
    output logic       in_reset_o,
    output logic       cap_ir_o,
    output logic       sh_ir_o,
    output logic       upd_ir_o,
    output logic       cap_dr_o,
    output logic       sh_dr_o,
    output logic       upd_dr_o
);

    tap_state_e state_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= tap_next(state_q, tms);
        end
    end

    assign state_o    = state_q;
    assign in_reset_o = (state_q == ST_RESET);
    assign cap_ir_o   = (state_q == ST_CAP_IR);
    assign sh_ir_o    = (state_q == ST_SH_IR);
    assign upd_ir_o   = (state_q == ST_UPD_IR);
    assign cap_dr_o   = (state_q == ST_CAP_DR);
    assign sh_dr_o    = (state_q == ST_SH_DR);
    assign upd_dr_o   = (state_q == ST_UPD_DR);

endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         rst,
    input  logic         cap_en,
    input  logic [W-1:0] cap_val,
    input  logic         sh_en,
    input  logic         si,
    output logic [W-1:0] par_o,
    output logic         so_o
);

    logic [W-1:0] sr_q;

    generate
        if (W == 1) begin : g_single
            always_ff @(posedge tck) begin
                if (rst) begin
                    sr_q <= '0;
                end else if (cap_en) begin
                    sr_q <= cap_val;
                end else if (sh_en) begin
                    sr_q <= si;
                end
            end
        end else begin : g_multi
            always_ff @(posedge tck) begin
                if (rst) begin
                    sr_q <= '0;
                end else if (cap_en) begin
                    sr_q <= cap_val;
                end else if (sh_en) begin
                    sr_q <= {si, sr_q[W-1:1]};
                end
            end
        end
    endgenerate

    assign par_o = sr_q;
    assign so_o  = sr_q[0];

endmodule

// File: rtl/tap_ir.sv
module tap_ir #(
    parameter int              IR_W     = 4,
    parameter logic [IR_W-1:0] CAPTURE  = '0,
    parameter logic [IR_W-1:0] RESET_OP = '0
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            sh,
    input  logic            upd,
    output logic            so_o,
    output logic [IR_W-1:0] instr_o
);

    logic [IR_W-1:0] shift_val;
    logic [IR_W-1:0] instr_q;

    tap_shreg #(.W(IR_W)) u_sr (
        .tck     (tck),
        .rst     (rst),
        .cap_en  (cap),
        .cap_val (CAPTURE),
        .sh_en   (sh),
        .si      (tdi),
        .par_o   (shift_val),
        .so_o    (so_o)
    );

    always_ff @(negedge tck) begin
        if (rst || in_reset) begin
            instr_q <= RESET_OP;
        end else if (upd) begin
            instr_q <= shift_val;
        end
    end

    assign instr_o = instr_q;

endmodule

// File: rtl/tap_tdo_out.sv
module tap_tdo_out (
    input  logic tck,
    input  logic rst,
    input  logic sh_ir,
    input  logic sh_dr,
    input  logic ir_so,
    input  logic dr_so,
    output logic tdo_o,
    output logic oe_o
);

    logic tdo_q;
    logic oe_q;

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q  <= sh_ir | sh_dr;
            tdo_q <= sh_ir ? ir_so : dr_so;
        end
    end

    assign tdo_o = tdo_q;
    assign oe_o  = oe_q;

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    input  logic       tdi,
    input  logic       bsr_so,
    output logic       tdo,
    output logic       tdo_oe,
    output logic [3:0] tap_state,
    output logic [3:0] instr,
    output logic       bsr_sel,
    output logic       bsr_extest,
    output logic       bsr_capture,
    output logic       bsr_shift,
    output logic       bsr_update
);

    tap_state_e state;
    logic in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
    logic ir_so, dr_so, pass_so, ident_so;
    logic [IR_W-1:0] instr_q;
    logic [0:0]      pass_par;
    logic [ID_W-1:0] ident_par;
    decode_t         dec;

    tap_fsm u_fsm (
        .tck        (tck),
        .rst        (rst),
        .tms        (tms),
        .state_o    (state),
        .in_reset_o (in_reset),
        .cap_ir_o   (cap_ir),
        .sh_ir_o    (sh_ir),
        .upd_ir_o   (upd_ir),
        .cap_dr_o   (cap_dr),
        .sh_dr_o    (sh_dr),
        .upd_dr_o   (upd_dr)
    );

    tap_ir #(
        .IR_W     (IR_W),
        .CAPTURE  (IR_CAPTURE),
        .RESET_OP (OP_IDENT)
    ) u_ir (
        .tck      (tck),
        .rst      (rst),
        .tdi      (tdi),
        .in_reset (in_reset),
        .cap      (cap_ir),
        .sh       (sh_ir),
        .upd      (upd_ir),
        .so_o     (ir_so),
        .instr_o  (instr_q)
    );

    assign dec = ir_decode(instr_q);

    tap_shreg #(.W(1)) u_pass (
        .tck     (tck),
        .rst     (rst),
        .cap_en  (cap_dr && dec.path == PATH_PASS),
        .cap_val (1'b0),
        .sh_en   (sh_dr && dec.path == PATH_PASS),
        .si      (tdi),
        .par_o   (pass_par),
        .so_o    (pass_so)
    );

    tap_shreg #(.W(ID_W)) u_ident (
        .tck     (tck),
        .rst     (rst),
        .cap_en  (cap_dr && dec.path == PATH_IDENT),
        .cap_val (ID_VALUE),
        .sh_en   (sh_dr && dec.path == PATH_IDENT),
        .si      (tdi),
        .par_o   (ident_par),
        .so_o    (ident_so)
    );

    always_comb begin
        case (dec.path)
            PATH_IDENT: dr_so = ident_so;
            PATH_BOUND: dr_so = bsr_so;
            default:    dr_so = pass_so;
        endcase
    end

    tap_tdo_out u_out (
        .tck   (tck),
        .rst   (rst),
        .sh_ir (sh_ir),
        .sh_dr (sh_dr),
        .ir_so (ir_so),
        .dr_so (dr_so),
        .tdo_o (tdo),
        .oe_o  (tdo_oe)
    );

    assign tap_state   = state;
    assign instr       = instr_q;
    assign bsr_sel     = (dec.path == PATH_BOUND);
    assign bsr_extest  = bsr_sel && dec.drive_out;
    assign bsr_capture = bsr_sel && cap_dr;
    assign bsr_shift   = bsr_sel && sh_dr;
    assign bsr_update  = bsr_sel && upd_dr;

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
(
    input logic       tck,
    input logic       rst,
    input logic       tms,
    input logic [3:0] tap_state,
    input logic [3:0] instr,
    input logic       tdo_oe,
    input logic       bsr_sel,
    input logic       bsr_extest,
    input logic       bsr_shift
);

    AST_TLR_HOLDS_IDENT: assert property (@(posedge tck) disable iff (rst)
        (tap_state == ST_RESET) |-> (instr == OP_IDENT)); // R2

    AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (rst)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (tap_state == ST_RESET)); // R2

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (tap_state == ST_SH_DR || tap_state == ST_SH_IR)); // R9

    AST_IR_HOLD: assert property (@(posedge tck) disable iff (rst)
        !(tap_state == ST_UPD_IR || tap_state == ST_RESET) |-> $stable(instr)); // R5

    AST_EXTEST_IMPLIES_SEL: assert property (@(posedge tck) disable iff (rst)
        bsr_extest |-> bsr_sel); // R8

    AST_SHIFT_STROBE_STATE: assert property (@(posedge tck) disable iff (rst)
        bsr_shift |-> (bsr_sel && tap_state == ST_SH_DR)); // R10

endmodule

bind jtag_tap_ctrl tap_ctrl_chk u_chk (
    .tck        (tck),
    .rst        (rst),
    .tms        (tms),
    .tap_state  (tap_state),
    .instr      (instr),
    .tdo_oe     (tdo_oe),
    .bsr_sel    (bsr_sel),
    .bsr_extest (bsr_extest),
    .bsr_shift  (bsr_shift)
);

// File: tb/sim_jtag_tap_ctrl.sv
module sim_jtag_tap_ctrl;

    localparam int TCK_PERIOD   = 20;
    localparam int SAMPLE_DLY   = TCK_PERIOD / 4;
    localparam int WATCHDOG_CYC = 20000;

    logic       tck = 1'b0;
    logic       rst = 1'b1;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       bsr_so = 1'b0;
    logic       tdo, tdo_oe, bsr_sel, bsr_extest, bsr_capture, bsr_shift, bsr_update;
    logic [3:0] tap_state, instr;

    typedef struct {
        logic  val;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_errors = 0;

    always #(TCK_PERIOD / 2) tck = ~tck;

    jtag_tap_ctrl u0 (
        .tck         (tck),
        .rst         (rst),
        .tms         (tms),
        .tdi         (tdi),
        .bsr_so      (bsr_so),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .tap_state   (tap_state),
        .instr       (instr),
        .bsr_sel     (bsr_sel),
        .bsr_extest  (bsr_extest),
        .bsr_capture (bsr_capture),
        .bsr_shift   (bsr_shift),
        .bsr_update  (bsr_update)
    );

    task automatic check_val(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Inputs change just after a falling edge; the next rising edge applies them.
    task automatic step(input logic tms_v, input logic tdi_v);
        @(negedge tck);
        #1;
        tms = tms_v;
        tdi = tdi_v;
    endtask

    task automatic expect_bit(input logic v, input string req);
        exp_t e;
        e.val = v;
        e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: one expected bit per low phase with the enable high.
    initial begin
        forever begin
            @(negedge tck);
            #SAMPLE_DLY;
            if (tdo_oe === 1'b1) begin
                if (sb_q.size() == 0) begin
                    check_val("R9", "tdo_oe high outside a shift phase", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    logic held;
                    e = sb_q.pop_front();
                    check_val(e.req, "tdo bit", {31'd0, tdo}, {31'd0, e.val});
                    held = tdo;
                    @(posedge tck);
                    #SAMPLE_DLY;
                    check_val("R9", "tdo moved at rising edge", {31'd0, tdo}, {31'd0, held});
                end
            end
        end
    end

    // Entry and exit: next step runs in the Run-Test/Idle phase.
    task automatic scan_ir(input logic [3:0] op, input logic [3:0] old_op);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i]);
            expect_bit(tap_pkg::IR_CAPTURE[i], "R4");
            if (i == 0) begin
                #(SAMPLE_DLY - 1);
                check_val("R3", "Shift-IR code", {28'd0, tap_state}, 32'hA);
            end
        end
        step(1'b1, 1'b0);
        #(SAMPLE_DLY - 1);
        check_val("R5", "instr held in Exit1-IR", {28'd0, instr}, {28'd0, old_op});
        step(1'b0, 1'b0);
        #(SAMPLE_DLY - 1);
        check_val("R5", "instr after Update-IR", {28'd0, instr}, {28'd0, op});
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] exp,
                           input string req, input logic bsr_exp);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            expect_bit(exp[i], req);
            if (i == 0) begin
                #(SAMPLE_DLY - 1);
                check_val("R3", "Shift-DR code", {28'd0, tap_state}, 32'h2);
                check_val("R10", "bsr_shift in Shift-DR", {31'd0, bsr_shift}, {31'd0, bsr_exp});
            end
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge tck);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] din;
        logic [63:0] exp;

        // Reset
        repeat (3) step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        rst = 1'b0;
        #(SAMPLE_DLY - 1);
        check_val("R1", "state after reset", {28'd0, tap_state}, 32'hF);
        check_val("R1", "instr after reset", {28'd0, instr}, 32'h2);
        check_val("R1", "tdo_oe after reset", {31'd0, tdo_oe}, 32'd0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        #(SAMPLE_DLY - 1);
        check_val("R3", "Run-Test/Idle code", {28'd0, tap_state}, 32'hC);
        check_val("R9", "tdo_oe low in idle", {31'd0, tdo_oe}, 32'd0);

        // Identity register, then tdi delayed 32
        din = 64'h0;
        din[3:0] = 4'b1101;
        exp = 64'h0;
        exp[31:0]  = 32'hC3C3C3C3;
        exp[35:32] = din[3:0];
        scan_dr(36, din, exp, "R6", 1'b0);

        // Pass-through opcode
        scan_ir(4'b1111, 4'b0010);
        #1;
        check_val("R7", "bsr_sel for 1111", {31'd0, bsr_sel}, 32'd0);
        din = 64'h00000000_000000B5;
        exp = {din[62:0], 1'b0};
        scan_dr(9, din, exp, "R7", 1'b0);

        // Undefined opcode behaves as pass-through
        scan_ir(4'b0101, 4'b1111);
        #1;
        check_val("R7", "bsr_sel for 0101", {31'd0, bsr_sel}, 32'd0);
        din = 64'h00000000_0000004E;
        exp = {din[62:0], 1'b0};
        scan_dr(8, din, exp, "R7", 1'b0);

        // Observe-only boundary opcode, with strobe checks
        scan_ir(4'b0001, 4'b0101);
        #1;
        check_val("R8", "bsr_sel for 0001", {31'd0, bsr_sel}, 32'd1);
        check_val("R8", "bsr_extest for 0001", {31'd0, bsr_extest}, 32'd0);
        bsr_so = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        #(SAMPLE_DLY - 1);
        check_val("R10", "bsr_capture in Capture-DR", {31'd0, bsr_capture}, 32'd1);
        check_val("R10", "bsr_shift in Capture-DR", {31'd0, bsr_shift}, 32'd0);
        step(1'b0, 1'b1);
        expect_bit(1'b1, "R8");
        step(1'b1, 1'b0);
        expect_bit(1'b1, "R8");
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        #(SAMPLE_DLY - 1);
        check_val("R10", "bsr_update in Update-DR", {31'd0, bsr_update}, 32'd1);

        // External-drive boundary opcode
        scan_ir(4'b0000, 4'b0001);
        #1;
        check_val("R8", "bsr_sel for 0000", {31'd0, bsr_sel}, 32'd1);
        check_val("R8", "bsr_extest for 0000", {31'd0, bsr_extest}, 32'd1);
        bsr_so = 1'b0;
        scan_dr(3, 64'h5, 64'h0, "R8", 1'b1);

        // Five TMS-high clocks from Pause-DR
        scan_ir(4'b1111, 4'b0000);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        repeat (5) step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        #(SAMPLE_DLY - 1);
        check_val("R2", "state after five tms-high", {28'd0, tap_state}, 32'hF);
        check_val("R2", "instr after five tms-high", {28'd0, instr}, 32'h2);
        step(1'b0, 1'b0);

        // Reset line during operation
        scan_ir(4'b1111, 4'b0010);
        step(1'b0, 1'b0);
        rst = 1'b1;
        step(1'b0, 1'b0);
        rst = 1'b0;
        #(SAMPLE_DLY - 1);
        check_val("R1", "state after mid-run reset", {28'd0, tap_state}, 32'hF);
        check_val("R1", "instr after mid-run reset", {28'd0, instr}, 32'h2);
        step(1'b0, 1'b0);
        #(SAMPLE_DLY - 1);
        check_val("R3", "idle after reset release", {28'd0, tap_state}, 32'hC);

        repeat (3) step(1'b0, 1'b0);
        check_val("R9", "unconsumed expected bits", sb_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule